// File: doc/BRIEF.md
# Seconds Countdown Alarm with Pending Interrupt

This block is a relative alarm for a chip's always-on domain. Software writes a number of seconds into a load register. While the counter is enabled, the value copied from that register drops by one on every one-second tick pulse. When the value steps from 1 to 0, the block latches a pending flag and the counter stays at zero.

The pending flag drives a level interrupt when interrupt enable is set. It drives a wakeup output when wakeup enable is set. Software clears the flag by writing a one to its status bit. A second, calendar-based alarm sits outside this block. Its enable, interrupt-enable and status registers exist here only as storage stubs, so software written for the full register map runs unchanged.

Software reaches all registers through a simple single-cycle write port and a combinational read port.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset every register reads 0, and both irq_o and wake_o are low.
- R2: A write to offset 0x20 stores the value, which reads back at 0x20. The same value is copied into the live count at 0x24 on the next cycle. This load takes priority over a tick in the same cycle.
- R3: While bit 0 of offset 0x28 (counter enable) is 1 and the live count is nonzero, each tick pulse lowers the live count by exactly one.
- R4: While counter enable is 0, tick pulses leave the live count unchanged.
- R5: When a tick moves the live count from 1 to 0, bit 0 of offset 0x30 (pending) becomes 1. Later ticks leave the count at 0. Loading 0 never sets pending.
- R6: Writing a word with bit 0 set to offset 0x30 clears pending. Writing bit 0 as 0 has no effect. An expiry in the same cycle as the clear leaves pending set.
- R7: irq_o is high exactly when pending is 1 and bit 0 of offset 0x2C (interrupt enable) is 1. It is a level and stays high until one of the two is cleared.
- R8: wake_o is high exactly when pending is 1 and bit 0 of offset 0x50 (wakeup enable) is 1.
- R9: Bit 0 written to offsets 0x44 and 0x48 (second-alarm stubs) reads back. Offset 0x4C always reads 0 and accepts writes. None of these three registers affects the count, pending, irq_o or wake_o.
- R10: The single-bit control registers store only bit 0 and read 0 in the other bits. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | 1 | Level interrupt: pending and interrupt enable |
| wake_o | output | 1 | Wakeup request: pending and wakeup enable |

## Verification
The countdown is exercised with short loads of one to six seconds. Ticks arrive on random cycles while the enable toggles, so pure decrements, frozen counts and expiries from 1 to 0 all occur. Each outcome shows up separately in the live count and in the pending bit.

Loads that coincide with ticks separate load priority from decrementing. Status writes with bit 0 at 0 and at 1 separate a true write-one-to-clear from a plain overwrite. Directed cases cover three further points. A clear in the same cycle as an expiry shows which of the two wins. Loading zero shows that no expiry is faked. Writes to the stub registers show that they never reach the interrupt or wakeup outputs.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // byte offsets of the register port
    localparam logic [7:0] OFF_LOAD  = 8'h20;
    localparam logic [7:0] OFF_CUR   = 8'h24;
    localparam logic [7:0] OFF_EN    = 8'h28;
    localparam logic [7:0] OFF_IE    = 8'h2C;
    localparam logic [7:0] OFF_STAT  = 8'h30;
    localparam logic [7:0] OFF_EN2   = 8'h44;
    localparam logic [7:0] OFF_IE2   = 8'h48;
    localparam logic [7:0] OFF_STAT2 = 8'h4C;
    localparam logic [7:0] OFF_WAKE  = 8'h50;

    // one-hot write selects produced by the decoder
    typedef struct packed {
        logic load;
        logic en;
        logic ie;
        logic stat;
        logic wake;
        logic en2;
        logic ie2;
    } wr_sel_t;

    // single-bit control flops
    typedef struct packed {
        logic en;
        logic ie;
        logic wake;
        logic en2;
        logic ie2;
    } ctrl_t;

endpackage

// File: rtl/alarm_bus_decode.sv
module alarm_bus_decode
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           sel
);

    always_comb begin
        sel      = '0;
        sel.load = wr && (addr == ADDR_W'(OFF_LOAD));
        sel.en   = wr && (addr == ADDR_W'(OFF_EN));
        sel.ie   = wr && (addr == ADDR_W'(OFF_IE));
        sel.stat = wr && (addr == ADDR_W'(OFF_STAT));
        sel.wake = wr && (addr == ADDR_W'(OFF_WAKE));
        sel.en2  = wr && (addr == ADDR_W'(OFF_EN2));
        sel.ie2  = wr && (addr == ADDR_W'(OFF_IE2));
    end

endmodule

// File: rtl/alarm_ctrl_regs.sv
module alarm_ctrl_regs
    import alarm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_sel_t sel,
    input  logic    wbit,
    output ctrl_t   ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (sel.en)   ctrl_d.en   = wbit;
        if (sel.ie)   ctrl_d.ie   = wbit;
        if (sel.wake) ctrl_d.wake = wbit;
        if (sel.en2)  ctrl_d.en2  = wbit;
        if (sel.ie2)  ctrl_d.ie2  = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              load_wr,
    input  logic              pend_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cur_val,
    output logic              pend
);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] cur;
        logic              pend;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (load_wr) begin
            st_d.load = wdata;
            st_d.cur  = wdata;
        end else if (run && tick && (st_q.cur != '0)) begin
            st_d.cur = st_q.cur - DATA_W'(1);
            expire_d = (st_q.cur == DATA_W'(1));
        end
        // expiry wins over a simultaneous clear
        if (expire_d)      st_d.pend = 1'b1;
        else if (pend_clr) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_val = st_q.load;
    assign cur_val  = st_q.cur;
    assign pend     = st_q.pend;

endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wake_o
);

    localparam logic [DATA_W-1:0] BIT0 = DATA_W'(1);

    wr_sel_t           sel;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] load_w;
    logic [DATA_W-1:0] cur_w;
    logic              pend_w;

    alarm_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .sel  (sel)
    );

    alarm_ctrl_regs u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wbit  (bus_wdata[0]),
        .ctrl  (ctrl)
    );

    alarm_countdown #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_i),
        .run      (ctrl.en),
        .load_wr  (sel.load),
        .pend_clr (sel.stat && bus_wdata[0]),
        .wdata    (bus_wdata),
        .load_val (load_w),
        .cur_val  (cur_w),
        .pend     (pend_w)
    );

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFF_LOAD))  bus_rdata = load_w;
        else if (bus_addr == ADDR_W'(OFF_CUR))   bus_rdata = cur_w;
        else if (bus_addr == ADDR_W'(OFF_EN))    bus_rdata = ctrl.en   ? BIT0 : '0;
        else if (bus_addr == ADDR_W'(OFF_IE))    bus_rdata = ctrl.ie   ? BIT0 : '0;
        else if (bus_addr == ADDR_W'(OFF_STAT))  bus_rdata = pend_w    ? BIT0 : '0;
        else if (bus_addr == ADDR_W'(OFF_EN2))   bus_rdata = ctrl.en2  ? BIT0 : '0;
        else if (bus_addr == ADDR_W'(OFF_IE2))   bus_rdata = ctrl.ie2  ? BIT0 : '0;
        else if (bus_addr == ADDR_W'(OFF_STAT2)) bus_rdata = '0;
        else if (bus_addr == ADDR_W'(OFF_WAKE))  bus_rdata = ctrl.wake ? BIT0 : '0;
    end

    assign irq_o  = pend_w & ctrl.ie;
    assign wake_o = pend_w & ctrl.wake;

endmodule

// File: rtl/alarm_chk.sv
module alarm_chk
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cur,
    input logic              pend,
    input logic              run,
    input logic              ie,
    input logic              irq_o,
    input logic              wake_o
);

    logic load_wr;
    assign load_wr = bus_wr && (bus_addr == ADDR_W'(OFF_LOAD));

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cur == $past(bus_wdata)));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_i && (cur != '0) && !load_wr) |=> (cur == $past(cur) - DATA_W'(1)));

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> $stable(cur));

    // R5
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ($past(tick_i) && ($past(cur) == DATA_W'(1)) && $past(run)));

    // R5
    stay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur == '0) && !load_wr) |=> (cur == '0));

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFF_STAT)) && bus_wdata[0]
         && !(run && tick_i && (cur == DATA_W'(1)) && !load_wr)) |=> !pend);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && ie));

    // R8
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> pend);

endmodule

bind sec_countdown_alarm alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cur       (cur_w),
    .pend      (pend_w),
    .run       (ctrl.en),
    .ie        (ctrl.ie),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/sec_countdown_alarm_test.sv
module sec_countdown_alarm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // bench model of the register state
    logic [31:0] m_load, m_cur;
    logic        m_pend, m_en, m_ie, m_wake, m_en2, m_ie2;

    always #4 clk = ~clk;

    sec_countdown_alarm uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic f_irq();
        return m_pend & m_ie;
    endfunction

    function automatic logic f_wake();
        return m_pend & m_wake;
    endfunction

    task automatic model_reset();
        m_load = 0; m_cur = 0; m_pend = 0; m_en = 0; m_ie = 0;
        m_wake = 0; m_en2 = 0; m_ie2 = 0;
    endtask

    task automatic model_step(input logic wr, input logic [7:0] a,
                              input logic [31:0] d, input logic tk);
        logic fire;
        fire = 1'b0;
        if (wr && a == 8'h20) begin
            m_load = d; m_cur = d;
        end else if (m_en && tk && m_cur != 0) begin
            fire = (m_cur == 1);
            m_cur = m_cur - 1;
        end
        if (fire) m_pend = 1'b1;
        else if (wr && a == 8'h30 && d[0]) m_pend = 1'b0;
        if (wr) begin
            case (a)
                8'h28: m_en   = d[0];
                8'h2C: m_ie   = d[0];
                8'h50: m_wake = d[0];
                8'h44: m_en2  = d[0];
                8'h48: m_ie2  = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic wr, input logic [7:0] a,
                       input logic [31:0] d, input logic tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_i = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        @(negedge clk);
        bus_wr = 1'b0; tick_i = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic outs(input string tag);
        chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, f_irq()});
        chk({tag, " wake"}, {31'b0, wake_o}, {31'b0, f_wake()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] dummy;
        dummy = $urandom(32'd17);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 load", 8'h20, 0); rd("R1 cur", 8'h24, 0); rd("R1 en", 8'h28, 0);
        rd("R1 stat", 8'h30, 0); rd("R1 wake", 8'h50, 0);
        chk("R1 irq", {31'b0, irq_o}, 0); chk("R1 wake_o", {31'b0, wake_o}, 0);

        // R2 load and copy, R10 bit-0 only
        cyc(1, 8'h20, 32'h1234_5678, 0);
        rd("R2 load rb", 8'h20, 32'h1234_5678); rd("R2 cur copy", 8'h24, 32'h1234_5678);
        cyc(1, 8'h28, 32'hFFFF_FFFF, 0);
        rd("R10 en bit0 only", 8'h28, 32'h1);
        rd("R10 unmapped", 8'h3C, 0);
        cyc(1, 8'h20, 32'd5, 1);
        rd("R2 load beats tick", 8'h24, 32'd5);

        // R3 countdown
        cyc(0, 8'h00, 0, 1); rd("R3 dec 5->4", 8'h24, 32'd4);
        cyc(0, 8'h00, 0, 0); rd("R3 no tick", 8'h24, 32'd4);
        cyc(0, 8'h00, 0, 1); rd("R3 dec 4->3", 8'h24, 32'd3);

        // R4 freeze
        cyc(1, 8'h28, 0, 1); rd("R4 tick w/ disable write uses old en", 8'h24, 32'd2);
        cyc(0, 8'h00, 0, 1); cyc(0, 8'h00, 0, 1);
        rd("R4 frozen", 8'h24, 32'd2);

        // R5 expiry, R7 and R8 gating
        cyc(1, 8'h28, 1, 0);
        cyc(0, 8'h00, 0, 1); rd("R5 at 1", 8'h24, 32'd1); rd("R5 not yet", 8'h30, 0);
        cyc(0, 8'h00, 0, 1); rd("R5 at 0", 8'h24, 0); rd("R5 pending", 8'h30, 1);
        chk("R7 irq masked", {31'b0, irq_o}, 0);
        chk("R8 wake masked", {31'b0, wake_o}, 0);
        cyc(0, 8'h00, 0, 1); rd("R5 stays zero", 8'h24, 0);
        cyc(1, 8'h2C, 1, 0); chk("R7 irq level", {31'b0, irq_o}, 1);
        cyc(0, 8'h00, 0, 0); chk("R7 irq held", {31'b0, irq_o}, 1);
        cyc(1, 8'h50, 1, 0); chk("R8 wake on", {31'b0, wake_o}, 1);

        // R9 stubs do not disturb anything
        cyc(1, 8'h44, 32'h3, 0); cyc(1, 8'h48, 32'h1, 0); cyc(1, 8'h4C, 32'h1, 0);
        rd("R9 en2", 8'h44, 1); rd("R9 ie2", 8'h48, 1); rd("R9 stat2", 8'h4C, 0);
        chk("R9 irq kept", {31'b0, irq_o}, 1); rd("R9 pend kept", 8'h30, 1);

        // R6 write-one-to-clear
        cyc(1, 8'h30, 32'hFFFF_FFFE, 0); rd("R6 zero write ignored", 8'h30, 1);
        cyc(1, 8'h30, 1, 0); rd("R6 cleared", 8'h30, 0);
        chk("R7 irq drops", {31'b0, irq_o}, 0); chk("R8 wake drops", {31'b0, wake_o}, 0);
        cyc(1, 8'h20, 1, 0);
        cyc(1, 8'h30, 1, 1); rd("R6 expiry beats clear", 8'h30, 1);
        cyc(1, 8'h30, 1, 0);
        cyc(1, 8'h20, 0, 0); cyc(0, 8'h00, 0, 1); cyc(0, 8'h00, 0, 1);
        rd("R5 load zero no pend", 8'h30, 0);

        // random mix, R3 R5 R6 R7 R8
        for (int i = 0; i < 2500; i++) begin
            int op;
            logic tk;
            op = $urandom % 10;
            tk = 1'($urandom % 2);
            case (op)
                0: cyc(1, 8'h20, 1 + ($urandom % 6), tk);
                1: cyc(1, 8'h28, $urandom, tk);
                2: cyc(1, 8'h2C, $urandom, tk);
                3: cyc(1, 8'h50, $urandom, tk);
                4: cyc(1, 8'h30, $urandom, tk);
                default: cyc(0, 8'h00, 0, tk);
            endcase
            outs("R7/R8 rand");
            rd("R3 rand cur", 8'h24, m_cur);
            rd("R5 rand pend", 8'h30, {31'b0, m_pend});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule